// File: doc/BRIEF.md
# Fully Associative Translation Buffer with Fence

This block caches virtual-to-physical page translations for a core. Each entry holds a virtual page number tag, a page size (4 KiB, 2 MiB or 1 GiB on a three-level, 9-bit-per-level page number), a physical page number, a global flag and four permission bits. The tag compare for a large page skips the page-number levels that the page covers. On a hit, those skipped bits pass straight from the lookup page number into the output physical page number. A lookup is combinational and resolves in the same cycle.

New translations come in on a refill port, one per cycle, from a page-table walker. The walker's memory accesses always run at supervisor privilege, so it never gets past memory protection on the core's behalf. A refill goes into the lowest-numbered empty entry. When every entry is valid, it replaces the entry named by a round-robin pointer, and the pointer moves on by one after each such replacement.

The fence port invalidates translations. It has no compare path of its own: the fence page number is presented on the lookup page-number input, and the lookup match lines pick which entries die. Two flags select the scope of a fence. With an address given, only the matching entries are removed. With an address-space operand given, global entries are kept. With neither, the whole buffer is cleared.

If a lookup matches more than one entry, the block does not merge the translations. It reports a miss and clears every entry at the next clock edge.

None of the ports has a valid/ready handshake. The lookup is combinational and can always be served. A refill is a one-cycle strobe with no back-pressure: if the block cannot take it, the refill is lost and the walker walks the page table again on the next miss.

Top module: `tlb_fa`

## Requirements
- R1: After reset every entry is invalid. A lookup with `lk_valid`=1 gives `lk_miss`=1 and `lk_hit`=0.
- R2: A 4 KiB entry (`refill_level`=0) hits only when all 27 page-number bits are equal. On a hit, `lk_ppn` equals the stored page number and `lk_perm` equals the stored permissions (bit 0 R, bit 1 W, bit 2 X, bit 3 U).
- R3: A 2 MiB entry (`refill_level`=1) ignores page-number bits [8:0], and a 1 GiB entry (`refill_level`=2) ignores bits [17:0]. On a hit, those low bits of `lk_ppn` are taken from `lk_vpn`.
- R4: A lookup with `lk_valid`=1 and no fence that matches two or more entries gives `lk_miss`=1 and `lk_hit`=0. At the next edge every entry becomes invalid, and a refill in that cycle is dropped.
- R5: A fence with `fence_addr_nz`=0 and `fence_asid_nz`=0 invalidates every entry at the next edge.
- R6: A fence with `fence_addr_nz`=0 and `fence_asid_nz`=1 invalidates all non-global entries and keeps the global ones.
- R7: A fence with `fence_addr_nz`=1 invalidates only the entries that match `lk_vpn`. When `fence_asid_nz`=1 as well, matching global entries are kept.
- R8: A refill writes the lowest-indexed invalid entry. When all entries are valid, it replaces the entry named by a round-robin pointer, which starts at 0 after reset and advances by one, wrapping, after each such replacement.
- R9: A refill in the same cycle as a fence is dropped.
- R10: While `fence_valid`=1, `lk_hit` and `lk_miss` are both 0.
- R11: With `lk_valid`=0, `lk_hit` and `lk_miss` are both 0, whatever the buffer holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| lk_valid | input | 1 | Lookup request |
| lk_vpn | input | 27 | Lookup page number; also the fence address |
| lk_hit | output | 1 | Exactly one entry matched |
| lk_miss | output | 1 | Lookup did not resolve to a single entry |
| lk_ppn | output | PPN_W | Translated physical page number |
| lk_perm | output | 4 | Permissions of the hit entry {U,X,W,R} |
| refill_valid | input | 1 | Refill strobe from the walker |
| refill_vpn | input | 27 | Refill tag |
| refill_ppn | input | PPN_W | Refill physical page number |
| refill_level | input | 2 | Page size: 0 = 4 KiB, 1 = 2 MiB, 2 = 1 GiB |
| refill_global | input | 1 | Entry is shared by all address spaces |
| refill_perm | input | 4 | Permissions {U,X,W,R} |
| fence_valid | input | 1 | Fence request |
| fence_addr_nz | input | 1 | Fence is limited to the address on `lk_vpn` |
| fence_asid_nz | input | 1 | Fence names an address space, so global entries survive |

## Verification
The bench builds the block with ENTRIES=4 and the default PPN_W=28. With four entries, a few refills fill the buffer, so round-robin replacement and the wrap of its pointer are reached within a handful of cycles. All three page sizes are placed in the buffer at once, which exercises the superpage masks at their bit boundaries. A deliberate overlap between a 2 MiB entry and a 4 KiB entry triggers the multiple-hit flush. Global and non-global entries are mixed so that every combination of fence flags shows which entries it kills and which it keeps.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  localparam int LEVELS   = 3;
  localparam int IDX_BITS = 9;
  localparam int VPN_W    = LEVELS * IDX_BITS;
  localparam int PERM_W   = 4;

  typedef enum logic [1:0] {
    LVL_4K = 2'd0,
    LVL_2M = 2'd1,
    LVL_1G = 2'd2
  } pg_level_e;

  // Number of low page-number bits a page of this size does not tag.
  function automatic int span_bits(input pg_level_e lvl);
    case (lvl)
      LVL_4K:  return 0;
      LVL_2M:  return IDX_BITS;
      default: return 2 * IDX_BITS;
    endcase
  endfunction
endpackage

// File: rtl/tlb_cam.sv
module tlb_cam
  import tlb_pkg::*;
#(
  parameter int ENTRIES = 32
) (
  input  logic [ENTRIES-1:0] valid_vec,
  input  logic [VPN_W-1:0]   tag_arr [ENTRIES],
  input  pg_level_e          lvl_arr [ENTRIES],
  input  logic [VPN_W-1:0]   probe_vpn,
  output logic [ENTRIES-1:0] match_vec
);
  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    logic [VPN_W-1:0] care;
    always_comb begin
      care         = {VPN_W{1'b1}} << span_bits(lvl_arr[g]);
      match_vec[g] = valid_vec[g] && (((tag_arr[g] ^ probe_vpn) & care) == '0);
    end
  end
endmodule

// File: rtl/tlb_victim.sv
module tlb_victim #(
  parameter int ENTRIES = 32,
  localparam int IW = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ENTRIES-1:0] valid_vec,
  input  logic               advance,
  output logic               full,
  output logic [IW-1:0]      idx
);
  logic [IW-1:0] rr_q;
  logic [IW-1:0] free_idx;
  logic          free_found;

  always_comb begin
    free_found = 1'b0;
    free_idx   = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (!valid_vec[i]) begin
        free_found = 1'b1;
        free_idx   = IW'(i);
      end
    end
  end

  assign full = !free_found;
  assign idx  = free_found ? free_idx : rr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      rr_q <= '0;
    else if (advance && full)
      rr_q <= (rr_q == IW'(ENTRIES - 1)) ? '0 : rr_q + 1'b1;
  end

  // R8: a refill into a non-full buffer lands on an empty entry
  assert_victim_free_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !full |-> !valid_vec[idx]);
endmodule

// File: rtl/tlb_xlate.sv
module tlb_xlate
  import tlb_pkg::*;
#(
  parameter int ENTRIES = 32,
  parameter int PPN_W   = 28
) (
  input  logic [ENTRIES-1:0] match_vec,
  input  logic [PPN_W-1:0]   ppn_arr  [ENTRIES],
  input  pg_level_e          lvl_arr  [ENTRIES],
  input  logic [PERM_W-1:0]  perm_arr [ENTRIES],
  input  logic [VPN_W-1:0]   vpn,
  output logic [PPN_W-1:0]   ppn_out,
  output logic [PERM_W-1:0]  perm_out
);
  localparam int MW = (PPN_W < VPN_W) ? PPN_W : VPN_W;

  logic [PPN_W-1:0] ppn_or;
  logic [1:0]       lvl_or;
  logic [PPN_W-1:0] vpn_ext;
  logic [PPN_W-1:0] low_mask;

  always_comb begin
    ppn_or   = '0;
    lvl_or   = '0;
    perm_out = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (match_vec[i]) begin
        ppn_or   = ppn_or | ppn_arr[i];
        lvl_or   = lvl_or | lvl_arr[i];
        perm_out = perm_out | perm_arr[i];
      end
    end
    vpn_ext          = '0;
    vpn_ext[MW-1:0]  = vpn[MW-1:0];
    low_mask         = ~({PPN_W{1'b1}} << span_bits(pg_level_e'(lvl_or)));
    ppn_out          = (ppn_or & ~low_mask) | (vpn_ext & low_mask);
  end
endmodule

// File: rtl/tlb_fa.sv
module tlb_fa
  import tlb_pkg::*;
#(
  parameter int ENTRIES = 32,
  parameter int PPN_W   = 28,
  localparam int IW = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lk_valid,
  input  logic [VPN_W-1:0]  lk_vpn,
  output logic              lk_hit,
  output logic              lk_miss,
  output logic [PPN_W-1:0]  lk_ppn,
  output logic [PERM_W-1:0] lk_perm,
  input  logic              refill_valid,
  input  logic [VPN_W-1:0]  refill_vpn,
  input  logic [PPN_W-1:0]  refill_ppn,
  input  logic [1:0]        refill_level,
  input  logic              refill_global,
  input  logic [PERM_W-1:0] refill_perm,
  input  logic              fence_valid,
  input  logic              fence_addr_nz,
  input  logic              fence_asid_nz
);
  logic [ENTRIES-1:0] valid_q;
  logic [ENTRIES-1:0] glob_q;
  logic [VPN_W-1:0]   tag_q  [ENTRIES];
  logic [PPN_W-1:0]   ppn_q  [ENTRIES];
  pg_level_e          lvl_q  [ENTRIES];
  logic [PERM_W-1:0]  perm_q [ENTRIES];

  logic [ENTRIES-1:0] match_vec;
  logic [ENTRIES-1:0] kill_vec;
  logic [IW-1:0]      vic_idx;
  logic               vic_full;
  logic               probe;
  logic               one_hit;
  logic               multi_hit;
  logic               refill_go;
  int                 hit_cnt;

  // Shared compare: lookups and address fences both drive lk_vpn.
  tlb_cam #(.ENTRIES(ENTRIES)) u_cam (
    .valid_vec (valid_q),
    .tag_arr   (tag_q),
    .lvl_arr   (lvl_q),
    .probe_vpn (lk_vpn),
    .match_vec (match_vec)
  );

  tlb_xlate #(.ENTRIES(ENTRIES), .PPN_W(PPN_W)) u_xlate (
    .match_vec (match_vec),
    .ppn_arr   (ppn_q),
    .lvl_arr   (lvl_q),
    .perm_arr  (perm_q),
    .vpn       (lk_vpn),
    .ppn_out   (lk_ppn),
    .perm_out  (lk_perm)
  );

  tlb_victim #(.ENTRIES(ENTRIES)) u_victim (
    .clk       (clk),
    .rst_n     (rst_n),
    .valid_vec (valid_q),
    .advance   (refill_go),
    .full      (vic_full),
    .idx       (vic_idx)
  );

  always_comb begin
    hit_cnt = 0;
    for (int i = 0; i < ENTRIES; i++) hit_cnt += int'(match_vec[i]);
  end

  assign probe     = lk_valid && !fence_valid;
  assign one_hit   = (hit_cnt == 1);
  assign multi_hit = probe && (hit_cnt > 1);
  assign lk_hit    = probe && one_hit;
  assign lk_miss   = probe && !one_hit;
  assign refill_go = refill_valid && !fence_valid && !multi_hit;

  always_comb begin
    for (int i = 0; i < ENTRIES; i++)
      kill_vec[i] = fence_valid && (!fence_addr_nz || match_vec[i]) &&
                    !(fence_asid_nz && glob_q[i]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= '0;
    end else if (multi_hit) begin
      valid_q <= '0;
    end else begin
      valid_q <= valid_q & ~kill_vec;
      if (refill_go) valid_q[vic_idx] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (refill_go) begin
      tag_q[vic_idx]  <= refill_vpn;
      ppn_q[vic_idx]  <= refill_ppn;
      lvl_q[vic_idx]  <= pg_level_e'(refill_level);
      perm_q[vic_idx] <= refill_perm;
      glob_q[vic_idx] <= refill_global;
    end
  end

  // R4: conflicting match empties the buffer
  assert_multihit_flush_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (probe && $countones(match_vec) > 1) |=> (valid_q == '0));

  // R5: unqualified fence empties the buffer
  assert_fence_all_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (fence_valid && !fence_addr_nz && !fence_asid_nz) |=> (valid_q == '0));

  // R6: address-space fence keeps global entries
  assert_global_kept_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (fence_valid && fence_asid_nz) |=> (($past(valid_q & glob_q) & ~valid_q) == '0));

  // R7: address fence keeps entries that do not match
  assert_addr_fence_local_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (fence_valid && fence_addr_nz) |=> (($past(valid_q & ~match_vec) & ~valid_q) == '0));

  // R9: no entry becomes valid across a fence cycle
  assert_refill_dropped_R9: assert property (@(posedge clk) disable iff (!rst_n)
    fence_valid |=> ((valid_q & ~$past(valid_q)) == '0));

  // R8: refill into a buffer with room adds exactly one entry
  assert_refill_grows_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (refill_go && !vic_full) |=> ($countones(valid_q) == $countones($past(valid_q)) + 1));
endmodule

// File: tb/tlb_fa_tb.sv
module tlb_fa_tb;
  localparam int ENTRIES = 4;
  localparam int PPN_W   = 28;
  localparam int VW      = 27;
  localparam int TW      = VW + 1 + PPN_W + 4;

  // {vpn, expect_hit, expect_ppn, expect_perm} probed after setup (R2, R3)
  localparam logic [TW-1:0] TBL [8] = '{
    {27'h0001234, 1'b1, 28'h00ABCDE, 4'h3},
    {27'h0001235, 1'b0, 28'h0000000, 4'h0},
    {27'h0140C00, 1'b1, 28'h0456200, 4'h5},
    {27'h0140C1F, 1'b1, 28'h045621F, 4'h5},
    {27'h0140E00, 1'b0, 28'h0000000, 4'h0},
    {27'h2812345, 1'b1, 28'h0812345, 4'hD},
    {27'h283FFFF, 1'b1, 28'h083FFFF, 4'hD},
    {27'h2840000, 1'b0, 28'h0000000, 4'h0}
  };

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             lk_valid = 1'b0;
  logic [VW-1:0]    lk_vpn = '0;
  logic             lk_hit, lk_miss;
  logic [PPN_W-1:0] lk_ppn;
  logic [3:0]       lk_perm;
  logic             refill_valid = 1'b0;
  logic [VW-1:0]    refill_vpn = '0;
  logic [PPN_W-1:0] refill_ppn = '0;
  logic [1:0]       refill_level = '0;
  logic             refill_global = 1'b0;
  logic [3:0]       refill_perm = '0;
  logic             fence_valid = 1'b0;
  logic             fence_addr_nz = 1'b0;
  logic             fence_asid_nz = 1'b0;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #2 clk = ~clk;

  tlb_fa #(.ENTRIES(ENTRIES), .PPN_W(PPN_W)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .lk_valid(lk_valid), .lk_vpn(lk_vpn), .lk_hit(lk_hit), .lk_miss(lk_miss),
    .lk_ppn(lk_ppn), .lk_perm(lk_perm),
    .refill_valid(refill_valid), .refill_vpn(refill_vpn), .refill_ppn(refill_ppn),
    .refill_level(refill_level), .refill_global(refill_global), .refill_perm(refill_perm),
    .fence_valid(fence_valid), .fence_addr_nz(fence_addr_nz), .fence_asid_nz(fence_asid_nz)
  );

  task automatic check_out(input string req, input logic eh, input logic [PPN_W-1:0] ep,
                           input logic [3:0] em);
    checks++;
    if (lk_hit !== eh || lk_miss !== !eh || (eh && (lk_ppn !== ep || lk_perm !== em))) begin
      fails++;
      $display("FAIL %s vpn=%h: hit=%b miss=%b ppn=%h perm=%h, expected hit=%b ppn=%h perm=%h",
               req, lk_vpn, lk_hit, lk_miss, lk_ppn, lk_perm, eh, ep, em);
    end
  endtask

  task automatic look(input string req, input logic [VW-1:0] v, input logic eh,
                      input logic [PPN_W-1:0] ep, input logic [3:0] em);
    @(negedge clk);
    lk_valid = 1'b1;
    lk_vpn   = v;
    #1;
    check_out(req, eh, ep, em);
    lk_valid = 1'b0;
  endtask

  task automatic refill(input logic [VW-1:0] v, input logic [PPN_W-1:0] p,
                        input logic [1:0] l, input logic g, input logic [3:0] m);
    @(negedge clk);
    refill_valid = 1'b1; refill_vpn = v; refill_ppn = p;
    refill_level = l; refill_global = g; refill_perm = m;
    @(posedge clk); #1;
    refill_valid = 1'b0;
  endtask

  task automatic fence(input logic [VW-1:0] v, input logic an, input logic sn,
                       input logic with_refill, input logic probe_on);
    @(negedge clk);
    lk_vpn = v; fence_valid = 1'b1; fence_addr_nz = an; fence_asid_nz = sn;
    lk_valid = probe_on;
    if (with_refill) begin
      refill_valid = 1'b1; refill_vpn = 27'h0000AAA; refill_ppn = 28'h0000AAA;
      refill_level = 2'd0; refill_global = 1'b0; refill_perm = 4'h1;
    end
    #1;
    if (probe_on) begin
      checks++;
      if (lk_hit !== 1'b0 || lk_miss !== 1'b0) begin
        fails++;
        $display("FAIL R10: hit=%b miss=%b during fence, expected 0 0", lk_hit, lk_miss);
      end
    end
    @(posedge clk); #1;
    fence_valid = 1'b0; refill_valid = 1'b0; lk_valid = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    look("R1", 27'h0001234, 1'b0, '0, '0);

    // setup: 4K, 2M, 1G(global) entries
    refill(27'h0001234, 28'h00ABCDE, 2'd0, 1'b0, 4'h3);
    refill(27'h0140C00, 28'h0456200, 2'd1, 1'b0, 4'h5);
    refill(27'h2800000, 28'h0800000, 2'd2, 1'b1, 4'hD);
    for (int i = 0; i < 8; i++) begin
      logic [TW-1:0] e;
      e = TBL[i];
      look(e[0] ? "R2" : "R3", e[TW-1 -: VW], e[PPN_W+4], e[PPN_W+3:4], e[3:0]);
    end

    // R11: idle lookup with a resident entry
    @(negedge clk);
    lk_valid = 1'b0; lk_vpn = 27'h0001234; #1;
    checks++;
    if (lk_hit !== 1'b0 || lk_miss !== 1'b0) begin
      fails++;
      $display("FAIL R11: hit=%b miss=%b, expected 0 0", lk_hit, lk_miss);
    end

    // R8: fill entry 3, then two replacements hit entries 0 and 1
    refill(27'h0000777, 28'h0000777, 2'd0, 1'b0, 4'h1);
    refill(27'h0000888, 28'h0000888, 2'd0, 1'b0, 4'h1);
    look("R8", 27'h0001234, 1'b0, '0, '0);
    look("R8", 27'h0000888, 1'b1, 28'h0000888, 4'h1);
    look("R8", 27'h0140C00, 1'b1, 28'h0456200, 4'h5);
    refill(27'h0000999, 28'h0000999, 2'd0, 1'b0, 4'h2);
    look("R8", 27'h0140C00, 1'b0, '0, '0);
    look("R8", 27'h0000999, 1'b1, 28'h0000999, 4'h2);
    look("R8", 27'h0000777, 1'b1, 28'h0000777, 4'h1);

    // R7 + R9: single-address fence with a concurrent refill
    fence(27'h0000777, 1'b1, 1'b0, 1'b1, 1'b0);
    look("R7", 27'h0000777, 1'b0, '0, '0);
    look("R7", 27'h0000888, 1'b1, 28'h0000888, 4'h1);
    look("R9", 27'h0000AAA, 1'b0, '0, '0);

    // R6: address-space fence keeps only the global 1G entry
    fence(27'h0, 1'b0, 1'b1, 1'b0, 1'b0);
    look("R6", 27'h0000888, 1'b0, '0, '0);
    look("R6", 27'h0000999, 1'b0, '0, '0);
    look("R6", 27'h2812345, 1'b1, 28'h0812345, 4'hD);

    // R7: address + address-space fence
    refill(27'h0000888, 28'h0000888, 2'd0, 1'b0, 4'h1);
    refill(27'h0000999, 28'h0000999, 2'd0, 1'b0, 4'h2);
    fence(27'h2812345, 1'b1, 1'b1, 1'b0, 1'b0);
    look("R7", 27'h2812345, 1'b1, 28'h0812345, 4'hD);
    fence(27'h0000999, 1'b1, 1'b1, 1'b0, 1'b0);
    look("R7", 27'h0000999, 1'b0, '0, '0);
    look("R7", 27'h0000888, 1'b1, 28'h0000888, 4'h1);

    // R4: overlapping 2M entry makes a double match
    refill(27'h0000999, 28'h0000999, 2'd0, 1'b0, 4'h2);
    refill(27'h0000800, 28'h0000000, 2'd1, 1'b0, 4'h7);
    @(negedge clk);
    lk_valid = 1'b1; lk_vpn = 27'h0000999; #1;
    check_out("R4", 1'b0, '0, '0);
    @(posedge clk); #1;
    lk_valid = 1'b0;
    look("R4", 27'h0000888, 1'b0, '0, '0);
    look("R4", 27'h2812345, 1'b0, '0, '0);

    // R5 + R10: full fence with a probe held during it
    refill(27'h0000888, 28'h0000888, 2'd0, 1'b0, 4'h1);
    refill(27'h2800000, 28'h0800000, 2'd2, 1'b1, 4'hD);
    look("R5", 27'h0000888, 1'b1, 28'h0000888, 4'h1);
    fence(27'h0000888, 1'b0, 1'b0, 1'b0, 1'b1);
    look("R5", 27'h0000888, 1'b0, '0, '0);
    look("R5", 27'h2812345, 1'b0, '0, '0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule